// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the interlock and bypass controller of an in-order integer pipeline. Each cycle it compares the source registers of the instruction waiting in decode with the destination tags of every older instruction still in flight. From that comparison it decides one of three things for each operand: read the register file, take a bypassed result, or hold the front of the pipeline for a cycle. It also turns a resolved branch into a squash of the wrong-path instructions, according to a branch policy chosen at build time.

The unit is purely combinational. Its outputs act in the same cycle as the tags it sees. It has two build-time layouts. The shallow layout has five stages: fetch, decode, execute, memory and write-back. The deep layout has ten stages, made by splitting each of those five into two sub-stages, with stage numbers running from 0 (oldest fetch sub-stage) upward. Forwarding can be built in or left out.

The consumer is the instruction in the last decode sub-stage. Producer slot j is the stage j+1 places behind it, so slot 0 is the first execute sub-stage. The write-back stage is the first write-back sub-stage. Branches resolve at the end of the last execute sub-stage.

Top module: `pipe_hazard_unit`

## Requirements
- R1: With the decode valid input low, hold_o and bubble_o are 0 and both bypass selects are 0.
- R2: A matching producer in the write-back stage or later gives select 0 and no hold, because the register file returns a value written in the same cycle.
- R3: With forwarding left out, a matching producer in any stage after decode and before write-back raises hold_o, and the selects stay 0.
- R4: In the shallow layout with forwarding, a matching non-late producer in execute gives select 1, and a matching producer in memory gives select 2. Neither raises a hold.
- R5: In the shallow layout with forwarding, a matching late (load) producer in execute raises hold_o for that cycle only. Once that producer reaches memory, the select is 2 with no hold.
- R6: In the deep layout with forwarding, a result is usable only from the end of the second sub-stage of a pair. A matching producer in execute sub-stage 1 holds. In execute sub-stage 2 it gives select 1 if not late and holds if late. In memory sub-stage 1 it gives select 2 if not late and holds if late. In memory sub-stage 2 it gives select 2. In write-back it gives select 0.
- R7: A source of register 0 never matches, and a producer slot whose valid bit is 0 never matches.
- R8: When several producers write the same register, the youngest one older than the consumer alone decides the select and the hold. Select codes are 0 = register file, 1 = execute result, 2 = memory result.
- R9: bubble_o equals hold_o. A squash overrides any hold: when redirect_o is 1, hold_o is 0 and both selects are 0.
- R10: The policy decides when a resolved branch squashes. Flush-on-branch squashes on every resolution, predict-not-taken squashes when the branch is taken, and predict-taken squashes when it is not taken. A squash sets redirect_o and every bit of flush_o, one bit per stage younger than the resolving stage. Otherwise flush_o is 0.
- R11: The two source operands are resolved independently. Each gets its own select, and a hold caused by either one raises hold_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_vld_i | input | 1 | Consumer in last decode sub-stage is valid |
| dec_rs1_i | input | RW | First source register of the consumer |
| dec_rs2_i | input | RW | Second source register of the consumer |
| prod_vld_i | input | NP | Valid bit per producer slot (slot 0 = first execute sub-stage) |
| prod_dst_i | input | NP x RW | Destination register per producer slot |
| prod_late_i | input | NP | Producer result comes from memory (load) |
| br_vld_i | input | 1 | A branch resolves this cycle |
| br_taken_i | input | 1 | Resolved branch outcome is taken |
| hold_o | output | 1 | Freeze fetch and decode stages |
| bubble_o | output | 1 | Inject an invalid slot into the first execute sub-stage |
| fwd_a_o | output | 2 | Bypass select for the first operand |
| fwd_b_o | output | 2 | Bypass select for the second operand |
| flush_o | output | NFL | Squash mask, one bit per stage younger than the resolving stage |
| redirect_o | output | 1 | Wrong path detected, refetch |

## Verification
The bench goes after several corner cases, each with its own failure sign.
- A load followed at once by a consumer must hold exactly while the load sits in execute. A unit that forwarded too early would return select 1 with no hold, and one that held too long would still hold once the load reaches memory.
- Duplicate writers of one register must resolve to the youngest. A reversed priority shows up as select 2 where 1 is expected, or as a missing hold when the younger writer is a load.
- In the deep layout, each producer position is checked for both late and non-late results, so an off-by-one in the sub-stage of the forward point shows up as a missing or extra hold.
- Register 0 and invalid producers must never create a hold or a select.
- A branch squash arriving together with a load hazard must win over the hold.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Bypass choice per source operand
    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_EX  = 2'd1,
        SEL_MEM = 2'd2
    } fwd_sel_e;

    // Build-time branch handling
    typedef enum logic [1:0] {
        BR_FLUSH   = 2'd0,
        BR_PRED_NT = 2'd1,
        BR_PRED_T  = 2'd2
    } br_pol_e;

endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match
    import hzd_pkg::*;
#(
    parameter int SPLIT  = 1,
    parameter bit FWD_EN = 1'b1,
    parameter int RW     = 5,
    parameter int NP     = 3
)(
    input  logic                   cons_vld,
    input  logic [RW-1:0]          src,
    input  logic [NP-1:0]          p_vld,
    input  logic [NP-1:0][RW-1:0]  p_dst,
    input  logic [NP-1:0]          p_late,
    output logic                   need_hold,
    output logic [1:0]             sel
);

    localparam int DEC_ST  = 2*SPLIT - 1;  // last decode sub-stage
    localparam int ALU_RDY = 3*SPLIT - 1;  // stage whose output carries ALU result
    localparam int LD_RDY  = 4*SPLIT - 1;  // stage whose output carries load data
    localparam int MEM_ST  = 3*SPLIT;      // first memory sub-stage
    localparam int WB_ST   = 4*SPLIT;      // register file write stage

    logic     stall_c;
    fwd_sel_e sel_c;

    // Walk from oldest to youngest so the youngest match is written last
    always_comb begin
        stall_c = 1'b0;
        sel_c   = SEL_RF;
        for (int j = NP-1; j >= 0; j--) begin
            if (p_vld[j] && (p_dst[j] == src) && (src != '0)) begin
                if (DEC_ST + 1 + j >= WB_ST) begin
                    stall_c = 1'b0;
                    sel_c   = SEL_RF;
                end else if (!FWD_EN) begin
                    stall_c = 1'b1;
                    sel_c   = SEL_RF;
                end else if (DEC_ST + 1 + j < (p_late[j] ? LD_RDY : ALU_RDY)) begin
                    stall_c = 1'b1;
                    sel_c   = SEL_RF;
                end else begin
                    stall_c = 1'b0;
                    sel_c   = (DEC_ST + 1 + j < MEM_ST) ? SEL_EX : SEL_MEM;
                end
            end
        end
    end

    assign need_hold = cons_vld & stall_c;
    assign sel       = (cons_vld && !stall_c) ? sel_c : SEL_RF;

    always_comb begin
        // R7
        zero_src_chk: assert (src != '0 || (!need_hold && sel == SEL_RF));
        // R3
        nofwd_sel_chk: assert (FWD_EN || sel == SEL_RF);
        // R8
        sel_code_chk: assert (sel != 2'd3);
    end

endmodule

// File: rtl/hzd_branch_ctl.sv
module hzd_branch_ctl
    import hzd_pkg::*;
#(
    parameter br_pol_e BR_POL = BR_PRED_NT,
    parameter int      NFL    = 2
)(
    input  logic           br_vld,
    input  logic           br_taken,
    output logic           squash,
    output logic [NFL-1:0] squash_vec
);

    logic wrong_path;

    always_comb begin
        unique case (BR_POL)
            BR_FLUSH:   wrong_path = 1'b1;
            BR_PRED_NT: wrong_path = br_taken;
            BR_PRED_T:  wrong_path = !br_taken;
            default:    wrong_path = 1'b1;
        endcase
    end

    assign squash     = br_vld & wrong_path;
    assign squash_vec = {NFL{squash}};

    always_comb begin
        // R10
        squash_cause_chk: assert (!squash || br_vld);
    end

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
    import hzd_pkg::*;
#(
    parameter bit      DEEP   = 1'b0,
    parameter bit      FWD_EN = 1'b1,
    parameter br_pol_e BR_POL = BR_PRED_NT,
    parameter int      RW     = 5,
    localparam int     SPLIT  = DEEP ? 2 : 1,
    localparam int     NP     = 3*SPLIT,
    localparam int     NFL    = 3*SPLIT - 1
)(
    input  logic                  dec_vld_i,
    input  logic [RW-1:0]         dec_rs1_i,
    input  logic [RW-1:0]         dec_rs2_i,
    input  logic [NP-1:0]         prod_vld_i,
    input  logic [NP-1:0][RW-1:0] prod_dst_i,
    input  logic [NP-1:0]         prod_late_i,
    input  logic                  br_vld_i,
    input  logic                  br_taken_i,
    output logic                  hold_o,
    output logic                  bubble_o,
    output logic [1:0]            fwd_a_o,
    output logic [1:0]            fwd_b_o,
    output logic [NFL-1:0]        flush_o,
    output logic                  redirect_o
);

    logic [1:0][RW-1:0] srcs;
    logic [1:0]         op_hold;
    logic [1:0][1:0]    op_sel;
    logic               squash;

    assign srcs = {dec_rs2_i, dec_rs1_i};

    for (genvar g = 0; g < 2; g++) begin : g_src
        hzd_src_match #(
            .SPLIT  (SPLIT),
            .FWD_EN (FWD_EN),
            .RW     (RW),
            .NP     (NP)
        ) u_match (
            .cons_vld  (dec_vld_i),
            .src       (srcs[g]),
            .p_vld     (prod_vld_i),
            .p_dst     (prod_dst_i),
            .p_late    (prod_late_i),
            .need_hold (op_hold[g]),
            .sel       (op_sel[g])
        );
    end

    hzd_branch_ctl #(
        .BR_POL (BR_POL),
        .NFL    (NFL)
    ) u_branch (
        .br_vld     (br_vld_i),
        .br_taken   (br_taken_i),
        .squash     (squash),
        .squash_vec (flush_o)
    );

    assign redirect_o = squash;
    assign hold_o     = (|op_hold) & !squash;
    assign bubble_o   = hold_o;
    assign fwd_a_o    = (squash || hold_o) ? SEL_RF : op_sel[0];
    assign fwd_b_o    = (squash || hold_o) ? SEL_RF : op_sel[1];

    always_comb begin
        // R9
        hold_flush_chk: assert (!(hold_o && redirect_o));
        // R1
        idle_quiet_chk: assert (dec_vld_i || (!hold_o && fwd_a_o == 2'd0 && fwd_b_o == 2'd0));
        // R11
        held_sel_chk: assert (!hold_o || (fwd_a_o == 2'd0 && fwd_b_o == 2'd0));
        // R10
        mask_match_chk: assert ((flush_o == '0) == !redirect_o);
    end

endmodule

// File: tb/pipe_hazard_unit_tb_top.sv
module pipe_hazard_unit_tb_top;
    import hzd_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // shallow, forwarding, predict-not-taken
    logic             a_dv, a_bv, a_bt;
    logic [4:0]       a_r1, a_r2;
    logic [2:0]       a_pv, a_pl;
    logic [2:0][4:0]  a_pd;
    logic             a_hold, a_bub, a_redir;
    logic [1:0]       a_fa, a_fb;
    logic [1:0]       a_fl;

    pipe_hazard_unit #(.DEEP(1'b0), .FWD_EN(1'b1), .BR_POL(BR_PRED_NT), .RW(5)) dut_i (
        .dec_vld_i(a_dv), .dec_rs1_i(a_r1), .dec_rs2_i(a_r2),
        .prod_vld_i(a_pv), .prod_dst_i(a_pd), .prod_late_i(a_pl),
        .br_vld_i(a_bv), .br_taken_i(a_bt),
        .hold_o(a_hold), .bubble_o(a_bub), .fwd_a_o(a_fa), .fwd_b_o(a_fb),
        .flush_o(a_fl), .redirect_o(a_redir));

    // deep, forwarding, predict-taken
    logic             d_dv, d_bv, d_bt;
    logic [4:0]       d_r1, d_r2;
    logic [5:0]       d_pv, d_pl;
    logic [5:0][4:0]  d_pd;
    logic             d_hold, d_bub, d_redir;
    logic [1:0]       d_fa, d_fb;
    logic [4:0]       d_fl;

    pipe_hazard_unit #(.DEEP(1'b1), .FWD_EN(1'b1), .BR_POL(BR_PRED_T), .RW(5)) dut_deep_i (
        .dec_vld_i(d_dv), .dec_rs1_i(d_r1), .dec_rs2_i(d_r2),
        .prod_vld_i(d_pv), .prod_dst_i(d_pd), .prod_late_i(d_pl),
        .br_vld_i(d_bv), .br_taken_i(d_bt),
        .hold_o(d_hold), .bubble_o(d_bub), .fwd_a_o(d_fa), .fwd_b_o(d_fb),
        .flush_o(d_fl), .redirect_o(d_redir));

    // shallow, no forwarding, flush-on-branch
    logic             n_dv, n_bv, n_bt;
    logic [4:0]       n_r1, n_r2;
    logic [2:0]       n_pv, n_pl;
    logic [2:0][4:0]  n_pd;
    logic             n_hold, n_bub, n_redir;
    logic [1:0]       n_fa, n_fb;
    logic [1:0]       n_fl;

    pipe_hazard_unit #(.DEEP(1'b0), .FWD_EN(1'b0), .BR_POL(BR_FLUSH), .RW(5)) dut_nofwd_i (
        .dec_vld_i(n_dv), .dec_rs1_i(n_r1), .dec_rs2_i(n_r2),
        .prod_vld_i(n_pv), .prod_dst_i(n_pd), .prod_late_i(n_pl),
        .br_vld_i(n_bv), .br_taken_i(n_bt),
        .hold_o(n_hold), .bubble_o(n_bub), .fwd_a_o(n_fa), .fwd_b_o(n_fb),
        .flush_o(n_fl), .redirect_o(n_redir));

    typedef struct packed {
        logic [3:0] req;
        logic       dv;
        logic [4:0] r1;
        logic [4:0] r2;
        logic [2:0] pv;   // bit0 execute, bit1 memory, bit2 write-back
        logic [4:0] d0;
        logic [4:0] d1;
        logic [4:0] d2;
        logic [2:0] pl;
        logic       bv;
        logic       bt;
        logic       eh;
        logic [1:0] ea;
        logic [1:0] eb;
        logic       ef;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        // R1 idle consumer
        '{4'd1,  1'b0, 5'd1, 5'd2, 3'b111, 5'd1, 5'd2, 5'd3, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
        // R4 ALU producer in execute
        '{4'd4,  1'b1, 5'd1, 5'd9, 3'b001, 5'd1, 5'd0, 5'd0, 3'b000, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0},
        // R4 producer in memory, second operand
        '{4'd4,  1'b1, 5'd9, 5'd2, 3'b010, 5'd0, 5'd2, 5'd0, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 1'b0},
        // R2 write-through in write-back
        '{4'd2,  1'b1, 5'd3, 5'd9, 3'b100, 5'd0, 5'd0, 5'd3, 3'b100, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
        // R5 load in execute holds
        '{4'd5,  1'b1, 5'd1, 5'd9, 3'b001, 5'd1, 5'd0, 5'd0, 3'b001, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0},
        // R5 load moved to memory, bubble in execute
        '{4'd5,  1'b1, 5'd1, 5'd9, 3'b010, 5'd0, 5'd1, 5'd0, 3'b010, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0},
        // R7 register zero
        '{4'd7,  1'b1, 5'd0, 5'd0, 3'b111, 5'd0, 5'd0, 5'd0, 3'b111, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
        // R7 invalid producer
        '{4'd7,  1'b1, 5'd1, 5'd1, 3'b000, 5'd1, 5'd1, 5'd1, 3'b111, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
        // R8 execute beats memory
        '{4'd8,  1'b1, 5'd5, 5'd5, 3'b011, 5'd5, 5'd5, 5'd0, 3'b000, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0},
        // R8 memory beats write-back
        '{4'd8,  1'b1, 5'd9, 5'd6, 3'b110, 5'd0, 5'd6, 5'd6, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 1'b0},
        // R8 younger load wins over older ALU writer
        '{4'd8,  1'b1, 5'd4, 5'd9, 3'b011, 5'd4, 5'd4, 5'd0, 3'b001, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0},
        // R11 independent operands
        '{4'd11, 1'b1, 5'd7, 5'd8, 3'b011, 5'd7, 5'd8, 5'd0, 3'b000, 1'b0, 1'b0, 1'b0, 2'd1, 2'd2, 1'b0},
        // R11 load hazard on second operand only
        '{4'd11, 1'b1, 5'd9, 5'd3, 3'b001, 5'd3, 5'd0, 5'd0, 3'b001, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0},
        // R9 squash beats load hold
        '{4'd9,  1'b1, 5'd1, 5'd9, 3'b001, 5'd1, 5'd0, 5'd0, 3'b001, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1},
        // R10 not-taken under predict-not-taken
        '{4'd10, 1'b1, 5'd1, 5'd9, 3'b001, 5'd1, 5'd0, 5'd0, 3'b000, 1'b1, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_all();
        a_dv = 0; a_r1 = 0; a_r2 = 0; a_pv = 0; a_pd = '0; a_pl = 0; a_bv = 0; a_bt = 0;
        d_dv = 0; d_r1 = 0; d_r2 = 0; d_pv = 0; d_pd = '0; d_pl = 0; d_bv = 0; d_bt = 0;
        n_dv = 0; n_r1 = 0; n_r2 = 0; n_pv = 0; n_pd = '0; n_pl = 0; n_bv = 0; n_bt = 0;
    endtask

    // deep layout expectations per slot (slot 0 = execute sub-stage 1)
    function automatic int deep_hold(input int j, input bit late);
        if (j == 0) return 1;
        if (j == 1 || j == 2) return late ? 1 : 0;
        return 0;
    endfunction

    function automatic int deep_sel(input int j, input bit late);
        if (deep_hold(j, late) != 0) return 0;
        if (j == 1) return 1;
        if (j == 2 || j == 3) return 2;
        return 0;
    endfunction

    initial begin
        idle_all();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset-like quiet state on all builds
        @(negedge clk);
        chk("R1", "idle hold", a_hold, 0);
        chk("R1", "idle sel a", a_fa, 0);
        chk("R10", "idle flush", a_fl, 0);
        chk("R1", "idle deep hold", d_hold, 0);
        chk("R1", "idle nofwd hold", n_hold, 0);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            a_dv = VEC[i].dv; a_r1 = VEC[i].r1; a_r2 = VEC[i].r2;
            a_pv = VEC[i].pv; a_pd = {VEC[i].d2, VEC[i].d1, VEC[i].d0};
            a_pl = VEC[i].pl; a_bv = VEC[i].bv; a_bt = VEC[i].bt;
            @(negedge clk);
            chk($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d hold", i), a_hold, VEC[i].eh);
            chk("R9", $sformatf("vec%0d bubble", i), a_bub, VEC[i].eh);
            chk($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d sel a", i), a_fa, VEC[i].ea);
            chk($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d sel b", i), a_fb, VEC[i].eb);
            chk("R10", $sformatf("vec%0d redirect", i), a_redir, VEC[i].ef);
            chk("R10", $sformatf("vec%0d flush mask", i), a_fl, VEC[i].ef ? 3 : 0);
        end

        // R6 deep layout, each slot with ALU and load producers
        for (int j = 0; j < 6; j++) begin
            for (int lt = 0; lt < 2; lt++) begin
                @(posedge clk);
                idle_all();
                d_dv = 1; d_r1 = 5'd12; d_r2 = 5'd13;
                d_pv[j] = 1'b1; d_pd[j] = 5'd12; d_pl[j] = lt[0];
                @(negedge clk);
                chk("R6", $sformatf("slot%0d late%0d hold", j, lt), d_hold, deep_hold(j, lt[0]));
                chk("R6", $sformatf("slot%0d late%0d sel", j, lt), d_fa, deep_sel(j, lt[0]));
                chk("R11", $sformatf("slot%0d other operand", j), d_fb, 0);
            end
        end

        // R8 deep: younger execute sub-stage 2 writer beats memory sub-stage 2
        @(posedge clk);
        idle_all();
        d_dv = 1; d_r2 = 5'd20;
        d_pv = 6'b001010; d_pd[1] = 5'd20; d_pd[3] = 5'd20;
        @(negedge clk);
        chk("R8", "deep youngest sel", d_fb, 1);

        // R10 predict-taken: taken keeps path, not-taken squashes 5 stages
        @(posedge clk);
        idle_all();
        d_bv = 1; d_bt = 1;
        @(negedge clk);
        chk("R10", "pred-taken taken flush", d_fl, 0);
        chk("R10", "pred-taken taken redirect", d_redir, 0);
        @(posedge clk);
        d_bt = 0;
        @(negedge clk);
        chk("R10", "pred-taken not-taken flush", d_fl, 31);
        chk("R10", "pred-taken not-taken redirect", d_redir, 1);

        // R3 no forwarding: execute and memory producers hold
        for (int j = 0; j < 3; j++) begin
            @(posedge clk);
            idle_all();
            n_dv = 1; n_r1 = 5'd3;
            n_pv[j] = 1'b1; n_pd[j] = 5'd3;
            @(negedge clk);
            chk(j == 2 ? "R2" : "R3", $sformatf("nofwd slot%0d hold", j), n_hold, j == 2 ? 0 : 1);
            chk("R3", $sformatf("nofwd slot%0d sel", j), n_fa, 0);
        end

        // R10 flush-on-branch squashes both outcomes, R9 over a hold
        @(posedge clk);
        idle_all();
        n_bv = 1; n_bt = 0;
        @(negedge clk);
        chk("R10", "flush policy not-taken", n_fl, 3);
        @(posedge clk);
        n_bt = 1; n_dv = 1; n_r1 = 5'd3; n_pv = 3'b001; n_pd[0] = 5'd3;
        @(negedge clk);
        chk("R10", "flush policy taken", n_fl, 3);
        chk("R9", "flush policy overrides hold", n_hold, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule